// File: doc/BRIEF.md
# Four-Channel Grouped PWM Controller

This block generates four pulse-width-modulated outputs from one shared time base. The time base advances on a tick picked from three sources, each a one-cycle enable on the system clock. The first is a slow tick at about 32 kHz. The second fires on every thirteenth reference cycle, which gives about 2 MHz. The third fires on every cycle, so the counters run at the full reference rate. Each channel has its own period and high-time values. Both are counted in ticks and written through a simple register write port.

The values written are shadow copies. A running channel takes them into use only when its current period ends, so a change in the middle of a period never cuts a pulse short. Several such groups sit side by side to make up a larger set of channels.

The four outputs share their pads with general-purpose I/O. A single enable bit passes ownership of all four pads to the controller at once, including pads whose channel stays idle. While the controller is disabled, every pad carries the GPIO value again.

Top module: `pwm_group`

## Requirements
- R1: Register writes happen when `wr_en_i` is high at a clock edge. Address 2*c holds the period of channel c and address 2*c+1 its high time, for c = 0..3. Address 8 is the control word: bit 0 is the enable, and bits 2:1 are the source select.
- R2: Source select 0 picks the slow tick, and so does the unused code 3. The slow tick fires once every SLOW_DIV system cycles.
- R3: Source select 1 picks a tick that fires once every 13 system cycles.
- R4: Source select 2 advances the channel counters on every system cycle.
- R5: `pin_sel_o` is all ones while the enable is set and all zeros while it is clear. All four bits change in the same cycle.
- R6: Each `pad_o` bit equals the matching `pwm_o` bit when `pin_sel_o` is set for that pad, and equals the matching `gpio_i` bit otherwise.
- R7: While disabled, `pwm_o` is 0 and every channel counter is held at the start of a period. Enabling the block starts each channel at the beginning of a fresh period, using its latest shadow values.
- R8: With period P and high time H, where 0 < H < P, a channel is high for the first H ticks of every P-tick period. A period of 0 behaves as a period of 1.
- R9: Writes made while the block runs take effect only after the current period of that channel has ended.
- R10: A high time of 0 holds the output low. A high time equal to or greater than the period holds the output high.
- R11: Both tick dividers count freely from reset. The thirteen-cycle tick fires in the 13th cycle after reset and in every 13th cycle after that, whether or not it is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System (reference) clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | CNT_W | Register write data |
| gpio_i | input | NUM_CH | GPIO values for the shared pads |
| pwm_o | output | NUM_CH | Raw PWM outputs |
| pin_sel_o | output | NUM_CH | Pad mux select, 1 = PWM owns the pad |
| pad_o | output | NUM_CH | Muxed pad values |

## Verification
The four channels run at the same time with different shapes:
- a short duty cycle,
- a duty cycle above one half,
- a high time of zero,
- a high time larger than the period.

The result must agree cycle by cycle with a counting model. A period rewrite in the middle of a pulse shows whether the update waits for the end of the period or cuts in early.

Each of the four source codes is applied in turn. The reserved code must give the same timing as the slow tick. The thirteen-cycle tick must keep the phase it has had since reset.

Changing the GPIO values while the block is enabled and then disabled shows whether the pads follow the ownership bit as a group.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;
  typedef enum logic [1:0] {
    SRC_SLOW  = 2'd0,
    SRC_DIV13 = 2'd1,
    SRC_FULL  = 2'd2,
    SRC_RSVD  = 2'd3
  } src_sel_e;

  localparam int unsigned FAST_DIV = 13;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
  import pwm_grp_pkg::*;
#(
  parameter int unsigned SLOW_DIV = 813
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_sel_e sel_i,
  output logic     tick_o,
  output logic     tick13_o
);
  localparam int unsigned SW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam int unsigned FW = $clog2(FAST_DIV);

  logic [SW-1:0] slow_cnt;
  logic [FW-1:0] fast_cnt;
  logic          tick_slow;

  assign tick_slow = (slow_cnt == SW'(SLOW_DIV - 1));
  assign tick13_o  = (fast_cnt == FW'(FAST_DIV - 1));

  // free-running dividers, phase fixed by reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slow_cnt <= '0;
      fast_cnt <= '0;
    end else begin
      slow_cnt <= tick_slow ? '0 : slow_cnt + 1'b1;
      fast_cnt <= tick13_o  ? '0 : fast_cnt + 1'b1;
    end
  end

  always_comb begin
    unique case (sel_i)
      SRC_DIV13: tick_o = tick13_o;
      SRC_FULL:  tick_o = 1'b1;
      default:   tick_o = tick_slow;
    endcase
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] per_shd_i,
  input  logic [CNT_W-1:0] hi_shd_i,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cnt_q, per_q, hi_q;
  logic             wrap;

  assign wrap = ({1'b0, cnt_q} + 1'b1) >= {1'b0, per_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
      hi_q  <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
      per_q <= per_shd_i;
      hi_q  <= hi_shd_i;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_q <= '0;
        per_q <= per_shd_i;
        hi_q  <= hi_shd_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // cnt_q < max(per,1): hi>=per gives constant high, hi==0 constant low
  assign pwm_o = en_i && (cnt_q < hi_q);
endmodule

// File: rtl/pwm_group.sv
module pwm_group
  import pwm_grp_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned SLOW_DIV = 813,
  parameter int unsigned ADDR_W   = $clog2(2 * NUM_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [NUM_CH-1:0] gpio_i,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [NUM_CH-1:0] pin_sel_o,
  output logic [NUM_CH-1:0] pad_o
);
  localparam int unsigned CTRL_ADDR = 2 * NUM_CH;

  logic     en_q;
  src_sel_e sel_q;
  logic     tick_sel, tick_13;
  logic     ctrl_wr;

  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      sel_q <= SRC_SLOW;
    end else if (ctrl_wr) begin
      en_q  <= wr_data_i[0];
      sel_q <= src_sel_e'(wr_data_i[2:1]);
    end
  end

  pwm_tick_gen #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_q),
    .tick_o   (tick_sel),
    .tick13_o (tick_13)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CNT_W-1:0] per_shd, hi_shd;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        per_shd <= '0;
        hi_shd  <= '0;
      end else if (wr_en_i) begin
        if (wr_addr_i == ADDR_W'(2 * c))     per_shd <= wr_data_i;
        if (wr_addr_i == ADDR_W'(2 * c + 1)) hi_shd  <= wr_data_i;
      end
    end

    pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_q),
      .tick_i    (tick_sel),
      .per_shd_i (per_shd),
      .hi_shd_i  (hi_shd),
      .pwm_o     (pwm_o[c])
    );

    assign pin_sel_o[c] = en_q;
    assign pad_o[c]     = pin_sel_o[c] ? pwm_o[c] : gpio_i[c];
  end
endmodule

// File: rtl/pwm_group_chk.sv
module pwm_group_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_q,
  input logic              tick_sel,
  input logic              tick_13,
  input logic [NUM_CH-1:0] gpio_i,
  input logic [NUM_CH-1:0] pwm_o,
  input logic [NUM_CH-1:0] pin_sel_o,
  input logic [NUM_CH-1:0] pad_o
);
  logic [3:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gap_q <= '0;
    else if (tick_13) gap_q <= '0;
    else              gap_q <= gap_q + 1'b1;
  end

  AST_PIN_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_sel_o == '0) || (pin_sel_o == '1)); // R5

  AST_GPIO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_o & ~pin_sel_o) == (gpio_i & ~pin_sel_o)); // R6

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_sel_o == '0) |-> (pwm_o == '0)); // R7

  AST_DIV13_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_13 |-> (gap_q == 4'd12)); // R11

  AST_NO_MIDTICK_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !tick_sel) |=> (!en_q || $stable(pwm_o))); // R9
endmodule

bind pwm_group pwm_group_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_q      (en_q),
  .tick_sel  (tick_sel),
  .tick_13   (tick_13),
  .gpio_i    (gpio_i),
  .pwm_o     (pwm_o),
  .pin_sel_o (pin_sel_o),
  .pad_o     (pad_o)
);

// File: tb/tb_pwm_group.sv
module tb_pwm_group;
  localparam int SLOW = 50;
  localparam int NCH  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0] gpio = '0;
  logic [3:0] pwm, pin_sel, pad;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R7";
  bit    done = 1'b0;

  // behavioural model state
  int m_per_shd[NCH], m_hi_shd[NCH], m_per[NCH], m_hi[NCH], m_cnt[NCH];
  int m_en = 0, m_sel = 0, m_d13 = 0, m_dslow = 0;

  always #10 clk = ~clk; // 50 MHz

  pwm_group #(.SLOW_DIV(SLOW)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .gpio_i    (gpio),
    .pwm_o     (pwm),
    .pin_sel_o (pin_sel),
    .pad_o     (pad)
  );

  always @(posedge clk) begin
    bit tick;
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_per_shd[c] = 0; m_hi_shd[c] = 0; m_per[c] = 0; m_hi[c] = 0; m_cnt[c] = 0;
      end
      m_en = 0; m_sel = 0; m_d13 = 0; m_dslow = 0;
    end else begin
      if (m_sel == 1)      tick = (m_d13 == 12);
      else if (m_sel == 2) tick = 1'b1;
      else                 tick = (m_dslow == SLOW - 1);
      for (int c = 0; c < NCH; c++) begin
        if (m_en == 0) begin
          m_cnt[c] = 0; m_per[c] = m_per_shd[c]; m_hi[c] = m_hi_shd[c];
        end else if (tick) begin
          if (m_cnt[c] + 1 >= m_per[c]) begin
            m_cnt[c] = 0; m_per[c] = m_per_shd[c]; m_hi[c] = m_hi_shd[c];
          end else m_cnt[c]++;
        end
      end
      m_d13   = (m_d13 == 12) ? 0 : m_d13 + 1;
      m_dslow = (m_dslow == SLOW - 1) ? 0 : m_dslow + 1;
      if (wr_en) begin
        // R1: control word at 8, channel c period at 2c, high time at 2c+1
        if (wr_addr == 4'd8) begin
          m_en = int'(wr_data[0]); m_sel = int'(wr_data[2:1]);
        end else if (wr_addr < 4'd8) begin
          if (wr_addr[0]) m_hi_shd[wr_addr[2:1]] = int'(wr_data);
          else            m_per_shd[wr_addr[2:1]] = int'(wr_data);
        end
      end
    end
  end

  always @(posedge clk) begin
    logic [3:0] e_pwm, e_sel, e_pad;
    #5;
    if (!done) begin
      for (int c = 0; c < NCH; c++) begin
        e_pwm[c] = (m_en != 0) && (m_cnt[c] < m_hi[c]);
        e_sel[c] = (m_en != 0);
        e_pad[c] = e_sel[c] ? e_pwm[c] : gpio[c];
      end
      checks += 3;
      if (pwm !== e_pwm) begin
        errors++; $display("FAIL %s pwm_o act %b exp %b", cur_req, pwm, e_pwm);
      end
      if (pin_sel !== e_sel) begin
        errors++; $display("FAIL R5 pin_sel_o act %b exp %b", pin_sel, e_sel);
      end
      if (pad !== e_pad) begin
        errors++; $display("FAIL R6 pad_o act %b exp %b", pad, e_pad);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      gpio = gpio + 4'd3;
    end
  end

  initial begin
    run(5);
    rst_n = 1'b1;
    cur_req = "R7";            // reset state: idle, GPIO owns pads
    run(20);
    cur_req = "R1";
    wr(4'd0, 16'd4); wr(4'd1, 16'd1);
    wr(4'd2, 16'd5); wr(4'd3, 16'd3);
    wr(4'd4, 16'd3); wr(4'd5, 16'd0);
    wr(4'd6, 16'd2); wr(4'd7, 16'd5);
    wr(4'd8, 16'h5);           // full rate, enabled
    cur_req = "R4 R8";
    run(60);
    cur_req = "R9";
    run(2);
    wr(4'd0, 16'd6); wr(4'd1, 16'd4);
    run(40);
    cur_req = "R10";
    run(20);
    cur_req = "R3 R11";
    wr(4'd8, 16'h3);
    run(300);
    cur_req = "R2";
    wr(4'd8, 16'h1);
    wr(4'd2, 16'd7);           // mid-run update on slow base
    run(1000);
    cur_req = "R2 reserved";
    wr(4'd8, 16'h7);
    run(700);
    cur_req = "R7";
    wr(4'd8, 16'h4);           // disable, keep full rate
    wr(4'd0, 16'd0); wr(4'd1, 16'd0);
    wr(4'd3, 16'd1);
    run(30);
    cur_req = "R8 R5";
    wr(4'd8, 16'h5);
    run(60);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog act hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule